// File: doc/BRIEF.md
# Secondary Interrupt Router

This block gathers up to 32 level-sensitive interrupt sources and reports them to a parent interrupt controller in two ways. All sources are ANDed with a software-controlled enable mask. Any surviving bit drives a single combined request line. A fixed window of sources (21 through 30 by default) can also be routed on their own, each to a dedicated parent line. That route is controlled by a passthrough-enable register which does not depend on the combining mask.

Software reaches the block through a simple register port. The port takes one access per cycle, selected by a word index (the byte offset divided by four), with 32-bit data. Registers that hold state are changed by write-one-to-set and write-one-to-clear words, so no read-modify-write is needed. Source 0 can also be raised by software through a latched soft request. All outputs are registered. A change at the inputs or a register write shows at the outputs one clock later.

The register port is plain control traffic and has no back-pressure. A read issued in cycle N always returns data with `rd_valid` high in cycle N+1. Writes take effect at the clock edge that ends the access cycle.

Top module: `sirq_router`

## Requirements
- R1: On reset the enable mask, the passthrough enable and the soft request are cleared. `parent_irq`, every `pass_irq` bit and `rd_valid` are low, and reads of words 2, 4 and 8 return zero.
- R2: Reading word 1 returns the raw level: `irq_src` as sampled in the read cycle, with the soft request ORed into bit 0.
- R3: Reading word 0 returns the raw level ANDed with the enable mask.
- R4: Writing word 2 ORs the write data into the enable mask. Reading word 2 returns the mask.
- R5: Writing word 3 clears every mask bit that is written as 1 and leaves the other bits as they are.
- R6: `parent_irq` is high in the cycle after a cycle in which (raw level AND mask) is nonzero, where the mask includes any write made in that cycle. Otherwise it is low.
- R7: Writing word 8 ORs in only bits 21 to 30 of the write data (mask 0x7FE00000) to the passthrough enable. Other written bits are dropped. Reading word 8 returns the passthrough enable.
- R8: Writing word 9 clears every passthrough-enable bit that is written as 1.
- R9: For i in 21..30, `pass_irq[i]` is high one cycle after `irq_src[i]` is high while passthrough bit i is set. It is low otherwise. All other `pass_irq` bits are always low.
- R10: A nonzero write to word 4 sets the soft request and a nonzero write to word 5 clears it. A zero write to either has no effect. Reading word 4 returns raw level bit 0 in bit 0, with every other bit zero.
- R11: A read returns `rd_valid` high with its data in the next cycle. Reads of any word other than 0, 1, 2, 4 and 8 return zero. Writes to words other than 2, 3, 4, 5, 8 and 9 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 32 | Level interrupt sources |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 32 | Read data |
| parent_irq | output | 1 | Combined masked request to the parent |
| pass_irq | output | 32 | Per-source passthrough lines (only 21..30 active) |

## Verification
The hardest state to reach from the ports is one where the mask and the passthrough enable disagree about the same source. Examples are a source in 21..30 that is passed through but masked off, or enabled in the mask but not passed through, all while the soft request is toggling bit 0 and the sources move in the same cycles as the writes. Directed steps first build each of these overlaps. A long stream of seeded random writes, clears, reads, unmapped accesses and source changes then follows. Every cycle is compared against a register-level model kept in the bench.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [3:0] {
    SEL_MSTAT   = 4'd0,
    SEL_RAW     = 4'd1,
    SEL_ENSET   = 4'd2,
    SEL_ENCLR   = 4'd3,
    SEL_SOFTSET = 4'd4,
    SEL_SOFTCLR = 4'd5,
    SEL_PTSET   = 4'd6,
    SEL_PTCLR   = 4'd7,
    SEL_NONE    = 4'd15
  } sirq_sel_e;

  // Word indices that carry behaviour (software layout).
  localparam int unsigned W_MSTAT = 0;
  localparam int unsigned W_RAW   = 1;
  localparam int unsigned W_EN    = 2;
  localparam int unsigned W_ENCLR = 3;
  localparam int unsigned W_SOFT  = 4;
  localparam int unsigned W_SOFTC = 5;
  localparam int unsigned W_PT    = 8;
  localparam int unsigned W_PTCLR = 9;

  function automatic sirq_sel_e word_decode(input logic [31:0] w);
    sirq_sel_e s;
    case (w)
      W_MSTAT: s = SEL_MSTAT;
      W_RAW:   s = SEL_RAW;
      W_EN:    s = SEL_ENSET;
      W_ENCLR: s = SEL_ENCLR;
      W_SOFT:  s = SEL_SOFTSET;
      W_SOFTC: s = SEL_SOFTCLR;
      W_PT:    s = SEL_PTSET;
      W_PTCLR: s = SEL_PTCLR;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sirq_ctrl_regs.sv
module sirq_ctrl_regs
  import sirq_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  sirq_sel_e       sel,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] pten_q,
  output logic            soft_q,
  output logic [NSRC-1:0] mask_nxt,
  output logic [NSRC-1:0] pten_nxt,
  output logic            soft_nxt
);

  logic [NSRC-1:0] pt_allow;

  // Which sources may use a dedicated parent line.
  for (genvar i = 0; i < NSRC; i++) begin : g_allow
    if (i >= PT_LO && i <= PT_HI) begin : g_in
      assign pt_allow[i] = 1'b1;
    end else begin : g_out
      assign pt_allow[i] = 1'b0;
    end
  end

  logic wdata_any;
  assign wdata_any = |wdata;

  always_comb begin
    mask_nxt = mask_q;
    pten_nxt = pten_q;
    soft_nxt = soft_q;
    if (wr_stb) begin
      case (sel)
        SEL_ENSET:   mask_nxt = mask_q | wdata;
        SEL_ENCLR:   mask_nxt = mask_q & ~wdata;
        SEL_SOFTSET: if (wdata_any) soft_nxt = 1'b1;
        SEL_SOFTCLR: if (wdata_any) soft_nxt = 1'b0;
        SEL_PTSET:   pten_nxt = pten_q | (wdata & pt_allow);
        SEL_PTCLR:   pten_nxt = pten_q & ~wdata;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pten_q <= '0;
      soft_q <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      pten_q <= pten_nxt;
      soft_q <= soft_nxt;
    end
  end

endmodule

// File: rtl/sirq_rd_port.sv
module sirq_rd_port
  import sirq_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  input  sirq_sel_e       sel,
  input  logic [NSRC-1:0] level,
  input  logic [NSRC-1:0] mask_q,
  input  logic [NSRC-1:0] pten_q,
  output logic            rd_valid,
  output logic [NSRC-1:0] rd_data
);

  logic [NSRC-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_MSTAT:   rd_mux = level & mask_q;
      SEL_RAW:     rd_mux = level;
      SEL_ENSET:   rd_mux = mask_q;
      SEL_SOFTSET: rd_mux[0] = level[0];
      SEL_PTSET:   rd_mux = pten_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_stb;
      rd_data  <= rd_stb ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/sirq_out_stage.sv
module sirq_out_stage #(
  parameter int NSRC  = 32,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] level_nxt,
  input  logic [NSRC-1:0] mask_nxt,
  input  logic [NSRC-1:0] pten_nxt,
  output logic            parent_irq,
  output logic [NSRC-1:0] pass_irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) parent_irq <= 1'b0;
    else        parent_irq <= |(level_nxt & mask_nxt);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_line
    if (i >= PT_LO && i <= PT_HI) begin : g_pt
      logic line_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= pten_nxt[i] & level_nxt[i];
      end
      assign pass_irq[i] = line_q;
    end else begin : g_tie
      assign pass_irq[i] = 1'b0;
    end
  end

endmodule

// File: rtl/sirq_router.sv
module sirq_router
  import sirq_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 10,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_src,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic              rd_valid,
  output logic [NSRC-1:0]   rd_data,
  output logic              parent_irq,
  output logic [NSRC-1:0]   pass_irq
);

  localparam logic [NSRC-1:0] SOFT_BIT = NSRC'(1);

  sirq_sel_e       sel;
  logic            wr_stb, rd_stb;
  logic [NSRC-1:0] mask_q, pten_q, mask_nxt, pten_nxt;
  logic            soft_q, soft_nxt;
  logic [NSRC-1:0] level_cur, level_nxt;

  assign sel    = word_decode(32'(bus_addr));
  assign wr_stb = bus_en & bus_we;
  assign rd_stb = bus_en & ~bus_we;

  assign level_cur = irq_src | (soft_q   ? SOFT_BIT : '0);
  assign level_nxt = irq_src | (soft_nxt ? SOFT_BIT : '0);

  sirq_ctrl_regs #(.NSRC(NSRC), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .sel(sel), .wdata(bus_wdata),
    .mask_q(mask_q), .pten_q(pten_q), .soft_q(soft_q),
    .mask_nxt(mask_nxt), .pten_nxt(pten_nxt), .soft_nxt(soft_nxt)
  );

  sirq_rd_port #(.NSRC(NSRC)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .sel(sel), .level(level_cur),
    .mask_q(mask_q), .pten_q(pten_q), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  sirq_out_stage #(.NSRC(NSRC), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_out (
    .clk(clk), .rst_n(rst_n), .level_nxt(level_nxt), .mask_nxt(mask_nxt),
    .pten_nxt(pten_nxt), .parent_irq(parent_irq), .pass_irq(pass_irq)
  );

endmodule

// File: rtl/sirq_router_chk.sv
module sirq_router_chk #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 10,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   irq_src,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rd_valid,
  input logic [NSRC-1:0]   rd_data,
  input logic              parent_irq,
  input logic [NSRC-1:0]   pass_irq,
  input logic [NSRC-1:0]   pten_q,
  input logic              soft_q
);

  logic [NSRC-1:0] window;
  always_comb begin
    window = '0;
    for (int i = PT_LO; i <= PT_HI; i++) window[i] = 1'b1;
  end

  logic readable;
  assign readable = (bus_addr == 0) || (bus_addr == 1) || (bus_addr == 2) ||
                    (bus_addr == 4) || (bus_addr == 8);

  assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(bus_en && !bus_we));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !readable) |=> (rd_data == '0));

  assert_pt_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pten_q & ~window) == '0);

  assert_pass_outside_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_irq & ~window) == '0);

  assert_pass_needs_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((pass_irq & ~$past(irq_src)) == '0));

  assert_parent_needs_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (parent_irq |-> ($past(|irq_src) || soft_q)));

endmodule

bind sirq_router sirq_router_chk #(
  .NSRC(NSRC), .ADDR_W(ADDR_W), .PT_LO(PT_LO), .PT_HI(PT_HI)
) u_chk (.*);

// File: tb/sirq_router_bench.sv
`timescale 1ns/1ps
module sirq_router_bench;

  localparam logic [31:0] PTM = 32'h7FE0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid, parent_irq;
  logic [31:0] rd_data, pass_irq;

  always #2 clk = ~clk;

  sirq_router u_sirq_router (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .parent_irq(parent_irq),
    .pass_irq(pass_irq)
  );

  int checks = 0, errors = 0;
  logic [31:0] m_mask = '0, m_pten = '0;
  logic        m_soft = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic string rd_tag(input int w);
    case (w)
      0: return "R3";
      1: return "R2";
      2: return "R4";
      4: return "R10";
      8: return "R7";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] model_read(input int w, input logic [31:0] raw);
    case (w)
      0: return raw & m_mask;
      1: return raw;
      2: return m_mask;
      4: return {31'b0, raw[0]};
      8: return m_pten;
      default: return 32'h0;
    endcase
  endfunction

  // Called at a negedge; returns at the next negedge after checking.
  task automatic step(input bit en, input bit we, input int w,
                      input logic [31:0] wd, input logic [31:0] src);
    logic [31:0] raw, exp_rd, exp_pass;
    logic        exp_par;
    bus_en = en; bus_we = we; bus_addr = 10'(w); bus_wdata = wd; irq_src = src;
    raw = src | {31'b0, m_soft};
    exp_rd = model_read(w, raw);
    if (en && we) begin
      case (w)
        2: m_mask = m_mask | wd;
        3: m_mask = m_mask & ~wd;
        4: if (wd != 0) m_soft = 1'b1;
        5: if (wd != 0) m_soft = 1'b0;
        8: m_pten = m_pten | (wd & PTM);
        9: m_pten = m_pten & ~wd;
        default: ;
      endcase
    end
    exp_par  = |((src | {31'b0, m_soft}) & m_mask);
    exp_pass = m_pten & src & PTM;
    @(negedge clk);
    check(rd_valid == (en && !we), "R11 rd_valid", 32'(rd_valid), 32'(en && !we));
    if (en && !we)
      check(rd_data == exp_rd, rd_tag(w), rd_data, exp_rd);
    check(parent_irq == exp_par, "R6 parent_irq", 32'(parent_irq), 32'(exp_par));
    check(pass_irq == exp_pass, "R9 pass_irq", pass_irq, exp_pass);
    bus_en = 1'b0;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(parent_irq == 1'b0, "R1 parent", 32'(parent_irq), 0);
    check(pass_irq == '0, "R1 pass", pass_irq, 0);
    check(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: state reads zero after reset
    step(1, 0, 2, 0, 0);
    step(1, 0, 8, 0, 0);
    step(1, 0, 4, 0, 0);

    // R2/R3/R4: raw vs masked
    step(1, 1, 2, 32'h0000_00F0, 32'h0000_0033);
    step(1, 0, 1, 0, 32'h0000_0033);
    step(1, 0, 0, 0, 32'h0000_0033);
    step(1, 0, 2, 0, 32'h0000_0033);
    // R5: clear only written ones
    step(1, 1, 3, 32'h0000_0030, 32'h0000_0033);
    step(1, 0, 2, 0, 32'h0000_0033);

    // R10: zero write ignored, nonzero set, read bit0, clear
    step(1, 1, 4, 0, 0);
    step(1, 0, 4, 0, 0);
    step(1, 1, 4, 32'h8000_0000, 0);
    step(1, 0, 4, 0, 0);
    step(1, 0, 1, 0, 0);
    step(1, 1, 2, 32'h1, 0);      // R6: soft drives parent via mask bit 0
    step(1, 1, 5, 0, 0);          // zero clear ignored
    step(1, 0, 4, 0, 0);
    step(1, 1, 5, 32'h10, 0);
    step(1, 0, 4, 0, 0);

    // R7/R8/R9: passthrough window, masked-off source still passes
    step(1, 1, 8, 32'hFFFF_FFFF, 32'h0200_0000);
    step(1, 0, 8, 0, 32'h0200_0000);
    step(1, 1, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(0, 0, 0, 0, 32'hFFFF_FFFF);
    step(1, 1, 9, 32'h0220_0000, 32'hFFFF_FFFF);
    step(1, 0, 8, 0, 32'hFFFF_FFFF);

    // R11: unmapped and write-only words
    step(1, 1, 7, 32'hFFFF_FFFF, 32'h5);
    step(1, 1, 0, 32'hFFFF_FFFF, 32'h5);
    step(1, 1, 1, 32'hFFFF_FFFF, 32'h5);
    step(1, 0, 2, 0, 32'h5);
    step(1, 0, 3, 0, 32'h5);
    step(1, 0, 9, 0, 32'h5);
    step(1, 0, 1023, 0, 32'h5);

    // Seeded random mix
    for (int n = 0; n < 600; n++) begin
      int pick, w;
      logic [31:0] wd, src;
      pick = int'($urandom_range(0, 10));
      case (pick)
        0: w = 0; 1: w = 1; 2: w = 2; 3: w = 3; 4: w = 4;
        5: w = 5; 6: w = 8; 7: w = 9;
        default: w = int'($urandom_range(0, 1023));
      endcase
      wd  = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
      src = $urandom & $urandom;
      step($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, w, wd, src);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule